// File: doc/BRIEF.md
# Latched counter access front

This block is the register front end of a bank of three 16-bit down-counters. A host reaches it through a 2-bit address with separate write and read strobes and an 8-bit data path. Address 3 is the control port. Addresses 0, 1 and 2 reach the three counters. A control write does one of two things. It can program the byte format of one counter, or it can freeze that counter's value in a snapshot so the host can read it safely while counting goes on.

Each counter keeps its own write byte pointer and read byte pointer. As a result, two-byte transfers to different counters may be interleaved freely. A read sequence and a write sequence on the same counter do not disturb each other either. The counting element itself is a plain down-counter. It steps once per clock-enable pulse while its gate is high.

Per counter there are three small state machines:
- **Write sequencer**: states `WS_LOW` and `WS_HIGH`. A two-byte write of the low byte moves `WS_LOW`→`WS_HIGH`. The high byte write moves `WS_HIGH`→`WS_LOW`. A program forces `WS_LOW`.
- **Read sequencer**: states `RS_LOW` and `RS_HIGH`. A two-byte read toggles between them. A program forces `RS_LOW`.
- **Output latch**: states `OL_TRACK` and `OL_HOLD`. A latch command moves `OL_TRACK`→`OL_HOLD`. The last byte read, or a program, moves `OL_HOLD`→`OL_TRACK`.

Top module: `tmr_access_front`

## Requirements
- R1: Addresses 0, 1 and 2 select counters 0, 1 and 2. Address 3 is the control port, and a read of address 3 returns 8'h00.
- R2: A control write has its counter select in bits 7:6 (values 0 to 2) and a nonzero format in bits 5:4. The formats are 01 = low byte only, 10 = high byte only, 11 = low byte then high byte. Such a write sets the format, returns both byte pointers to the low byte and releases any held snapshot. It leaves the count unchanged. After reset every counter has format 11, a count of 0 and both pointers at the low byte.
- R3: In format 01, a counter write loads {8'h00, data}. In format 10, it loads {data, 8'h00}. In either format, a read returns the low byte or the high byte respectively.
- R4: In format 11, the first write is staged and the count keeps running. The second write loads {second, first} into the counting element.
- R5: A control write with bits 5:4 = 00 is a latch command for the counter in bits 7:6; bits 3:0 are ignored. It captures the count from the cycle it is issued, and reads return that snapshot while it is held. It never changes any format.
- R6: A latch command to a counter that already holds a snapshot is ignored. The snapshot keeps the value from the first command.
- R7: The snapshot is released after the last byte of the format has been read: one read in formats 01 and 10, two reads in format 11. Later reads follow the live count again.
- R8: Byte pointers are kept per counter, so two-byte accesses to other counters may fall between the two bytes of one counter.
- R9: The read pointer and the write pointer of one counter advance independently of each other.
- R10: A control write with select 11 (read-back code) changes no format, pointer, snapshot or count.
- R11: A counter decrements by one on each cycle where its clock enable and its gate are both high, wrapping from 16'h0000 to 16'hFFFF. It holds when its gate is low, and a load in the same cycle takes precedence.
- R12: A read of a counter with no snapshot held returns the byte of the live count at that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 2 | Register address: 0 to 2 counters, 3 control |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe; the pointer advances at the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from address and pointer state |
| cnt_ce | input | 3 | Per-counter clock-enable pulse |
| cnt_gate | input | 3 | Per-counter gate; counting only while high |

## Verification
The properties assume that `wr_en` and `rd_en` are never high in the same cycle. In other words, each cycle carries at most one access, so a program, a latch, a counter write and a read can never coincide. The bench keeps to this by issuing exactly one operation per cycle, drawn at random from idle, read, counter write, program, latch and read-back. Clock enables and gates are randomised independently on every cycle, so snapshots are taken while counts are moving. Directed sequences cover the wrap from zero, repeated latch commands and interleaved two-byte transfers.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    // Code in bits 5:4 of a control write
    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_BOTH  = 2'b11
    } acc_fmt_e;

    typedef enum logic {WS_LOW = 1'b0, WS_HIGH = 1'b1} wr_seq_e;
    typedef enum logic {RS_LOW = 1'b0, RS_HIGH = 1'b1} rd_seq_e;
    typedef enum logic {OL_TRACK = 1'b0, OL_HOLD = 1'b1} ol_state_e;
endpackage

// File: rtl/tmr_ctrl_decode.sv
module tmr_ctrl_decode
    import tmr_pkg::*;
#(
    parameter int NCH = 3,
    parameter int AW  = 2,
    parameter int DW  = 8
) (
    input  logic           wr_en,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    output logic [NCH-1:0] prog,
    output logic [NCH-1:0] latch,
    output acc_fmt_e       prog_fmt
);
    localparam logic [AW-1:0] CTRL = AW'((1 << AW) - 1);

    logic ctl_wr;
    assign ctl_wr   = wr_en && (addr == CTRL);
    assign prog_fmt = acc_fmt_e'(wdata[5:4]);

    for (genvar g = 0; g < NCH; g++) begin : g_sel
        logic hit;
        assign hit      = ctl_wr && (wdata[7:6] == 2'(g));
        assign prog[g]  = hit && (wdata[5:4] != ACC_LATCH);
        assign latch[g] = hit && (wdata[5:4] == ACC_LATCH);
    end
endmodule

// File: rtl/tmr_down_ctr.sv
module tmr_down_ctr #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce,
    input  logic          gate,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (ce && gate)
            count <= count - 1'b1;
    end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int DW = 8,
    localparam int CW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog,
    input  acc_fmt_e      prog_fmt,
    input  logic          latch,
    input  logic          wr,
    input  logic          rd,
    input  logic [DW-1:0] wdata,
    input  logic          ce,
    input  logic          gate,
    output logic [DW-1:0] rbyte,
    output acc_fmt_e      fmt_o,
    output logic          held_o,
    output logic [CW-1:0] snap_o,
    output logic [CW-1:0] count_o
);
    acc_fmt_e      fmt_q;
    wr_seq_e       wr_q, wr_next;
    rd_seq_e       rd_q, rd_next;
    ol_state_e     ol_q, ol_next;
    logic [DW-1:0] hold_q;
    logic [CW-1:0] snap_q;
    logic [CW-1:0] count;
    logic          load, stage, take_snap, last_rd;
    logic [CW-1:0] load_val;
    logic [CW-1:0] src;

    tmr_down_ctr #(.CW(CW)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce       (ce),
        .gate     (gate),
        .load     (load),
        .load_val (load_val),
        .count    (count)
    );

    // State registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= WS_LOW;
            rd_q <= RS_LOW;
            ol_q <= OL_TRACK;
        end else begin
            wr_q <= wr_next;
            rd_q <= rd_next;
            ol_q <= ol_next;
        end
    end

    // Data registers steered by the state machines
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_q  <= ACC_BOTH;
            hold_q <= '0;
            snap_q <= '0;
        end else begin
            if (prog)      fmt_q  <= prog_fmt;
            if (stage)     hold_q <= wdata;
            if (take_snap) snap_q <= count;
        end
    end

    // Next state and outputs
    always_comb begin
        wr_next   = wr_q;
        rd_next   = rd_q;
        ol_next   = ol_q;
        load      = 1'b0;
        load_val  = count;
        stage     = 1'b0;
        take_snap = 1'b0;
        last_rd   = 1'b0;

        if (prog) begin
            wr_next = WS_LOW;
        end else if (wr) begin
            unique case (fmt_q)
                ACC_LO: begin
                    load     = 1'b1;
                    load_val = {{DW{1'b0}}, wdata};
                end
                ACC_HI: begin
                    load     = 1'b1;
                    load_val = {wdata, {DW{1'b0}}};
                end
                ACC_BOTH: begin
                    unique case (wr_q)
                        WS_LOW: begin
                            stage   = 1'b1;
                            wr_next = WS_HIGH;
                        end
                        WS_HIGH: begin
                            load     = 1'b1;
                            load_val = {wdata, hold_q};
                            wr_next  = WS_LOW;
                        end
                    endcase
                end
                default: ;
            endcase
        end

        if (prog) begin
            rd_next = RS_LOW;
        end else if (rd) begin
            if (fmt_q == ACC_BOTH) begin
                unique case (rd_q)
                    RS_LOW:  rd_next = RS_HIGH;
                    RS_HIGH: begin
                        rd_next = RS_LOW;
                        last_rd = 1'b1;
                    end
                endcase
            end else begin
                last_rd = 1'b1;
            end
        end

        unique case (ol_q)
            OL_TRACK: if (latch) begin
                ol_next   = OL_HOLD;
                take_snap = 1'b1;
            end
            OL_HOLD: if (prog || last_rd) ol_next = OL_TRACK;
        endcase

        src = (ol_q == OL_HOLD) ? snap_q : count;
        if (fmt_q == ACC_HI || (fmt_q == ACC_BOTH && rd_q == RS_HIGH))
            rbyte = src[CW-1:DW];
        else
            rbyte = src[DW-1:0];
    end

    assign fmt_o   = fmt_q;
    assign held_o  = (ol_q == OL_HOLD);
    assign snap_o  = snap_q;
    assign count_o = count;
endmodule

// File: rtl/tmr_access_front.sv
module tmr_access_front
    import tmr_pkg::*;
#(
    parameter int NCH = 3,
    parameter int DW  = 8,
    parameter int AW  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  addr,
    input  logic           wr_en,
    input  logic           rd_en,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    input  logic [NCH-1:0] cnt_ce,
    input  logic [NCH-1:0] cnt_gate
);
    localparam int CW = 2 * DW;

    logic [NCH-1:0]           prog, latch;
    acc_fmt_e                 prog_fmt;
    logic [NCH-1:0][DW-1:0]   rbyte;
    logic [NCH-1:0][1:0]      ch_fmt;
    logic [NCH-1:0]           ch_held;
    logic [NCH-1:0][CW-1:0]   ch_snap;
    logic [NCH-1:0][CW-1:0]   ch_count;

    tmr_ctrl_decode #(.NCH(NCH), .AW(AW), .DW(DW)) u_dec (
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .prog     (prog),
        .latch    (latch),
        .prog_fmt (prog_fmt)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        acc_fmt_e fmt_w;
        logic     sel;
        assign sel       = (addr == AW'(g));
        assign ch_fmt[g] = fmt_w;

        tmr_chan #(.DW(DW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .prog     (prog[g]),
            .prog_fmt (prog_fmt),
            .latch    (latch[g]),
            .wr       (wr_en && sel),
            .rd       (rd_en && sel),
            .wdata    (wdata),
            .ce       (cnt_ce[g]),
            .gate     (cnt_gate[g]),
            .rbyte    (rbyte[g]),
            .fmt_o    (fmt_w),
            .held_o   (ch_held[g]),
            .snap_o   (ch_snap[g]),
            .count_o  (ch_count[g])
        );
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++)
            if (addr == AW'(i)) rdata = rbyte[i];
    end
endmodule

// File: rtl/tmr_access_front_chk.sv
module tmr_access_front_chk #(
    parameter int NCH = 3,
    parameter int DW  = 8,
    parameter int AW  = 2,
    localparam int CW = 2 * DW
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [AW-1:0]          addr,
    input logic                   wr_en,
    input logic                   rd_en,
    input logic [DW-1:0]          wdata,
    input logic [NCH-1:0]         cnt_ce,
    input logic [NCH-1:0]         cnt_gate,
    input logic [NCH-1:0][1:0]    ch_fmt,
    input logic [NCH-1:0]         ch_held,
    input logic [NCH-1:0][CW-1:0] ch_snap,
    input logic [NCH-1:0][CW-1:0] ch_count
);
    localparam logic [AW-1:0] CTRL = AW'((1 << AW) - 1);

    logic ctl_wr;
    assign ctl_wr = wr_en && (addr == CTRL);

    p_latch_keeps_fmt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wdata[5:4] == 2'b00) |=> $stable(ch_fmt));

    p_readback_inert_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wdata[7:6] == 2'b11) |=> ($stable(ch_fmt) && $stable(ch_held) && $stable(ch_snap)));

    for (genvar g = 0; g < NCH; g++) begin : g_p
        p_repeat_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_wr && wdata[5:4] == 2'b00 && wdata[7:6] == 2'(g) && ch_held[g])
            |=> (ch_held[g] && $stable(ch_snap[g])));

        p_snapshot_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_held[g] && !ctl_wr && !(rd_en && addr == AW'(g)))
            |=> (ch_held[g] && $stable(ch_snap[g])));

        p_gate_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (!cnt_gate[g] && !(wr_en && addr == AW'(g))) |=> $stable(ch_count[g]));

        p_decrement_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_ce[g] && cnt_gate[g] && !(wr_en && addr == AW'(g)))
            |=> (ch_count[g] == CW'($past(ch_count[g]) - 1'b1)));
    end
endmodule

bind tmr_access_front tmr_access_front_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wdata    (wdata),
    .cnt_ce   (cnt_ce),
    .cnt_gate (cnt_gate),
    .ch_fmt   (ch_fmt),
    .ch_held  (ch_held),
    .ch_snap  (ch_snap),
    .ch_count (ch_count)
);

// File: tb/tmr_access_front_test.sv
module tmr_access_front_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [2:0] cnt_ce = '0, cnt_gate = '0;

    int checks = 0, fails = 0;
    bit finished = 0;

    // Reference model
    logic [15:0] m_count [3];
    logic [15:0] m_snap  [3];
    logic [7:0]  m_hold  [3];
    logic [1:0]  m_fmt   [3];
    bit          m_wptr  [3];
    bit          m_rptr  [3];
    bit          m_held  [3];

    logic [2:0] g_ce = '0, g_gt = '0;

    tmr_access_front uut (
        .clk (clk), .rst_n (rst_n), .addr (addr), .wr_en (wr_en), .rd_en (rd_en),
        .wdata (wdata), .rdata (rdata), .cnt_ce (cnt_ce), .cnt_gate (cnt_gate)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] exp_byte(logic [1:0] a);
        logic [15:0] s;
        if (a == 2'd3) return 8'h00;
        s = m_held[a] ? m_snap[a] : m_count[a];
        if (m_fmt[a] == 2'b10 || (m_fmt[a] == 2'b11 && m_rptr[a])) return s[15:8];
        return s[7:0];
    endfunction

    function automatic void model_edge(bit w, bit r, logic [1:0] a, logic [7:0] d,
                                       logic [2:0] ce, logic [2:0] gt);
        for (int ch = 0; ch < 3; ch++) begin
            bit prog, lat, loaded, last;
            logic [15:0] c;
            prog   = w && a == 2'd3 && d[5:4] != 2'b00 && d[7:6] == 2'(ch);
            lat    = w && a == 2'd3 && d[5:4] == 2'b00 && d[7:6] == 2'(ch);
            c      = m_count[ch];
            loaded = 0;
            if (w && a == 2'(ch)) begin
                case (m_fmt[ch])
                    2'b01: begin c = {8'h00, d}; loaded = 1; end
                    2'b10: begin c = {d, 8'h00}; loaded = 1; end
                    default: if (!m_wptr[ch]) begin m_hold[ch] = d; m_wptr[ch] = 1; end
                             else begin c = {d, m_hold[ch]}; m_wptr[ch] = 0; loaded = 1; end
                endcase
            end
            if (!loaded && ce[ch] && gt[ch]) c = m_count[ch] - 16'd1;
            if (prog) begin
                m_fmt[ch] = d[5:4]; m_wptr[ch] = 0; m_rptr[ch] = 0; m_held[ch] = 0;
            end else if (lat && !m_held[ch]) begin
                m_held[ch] = 1; m_snap[ch] = m_count[ch];
            end
            if (r && a == 2'(ch)) begin
                last = (m_fmt[ch] != 2'b11) || m_rptr[ch];
                if (m_fmt[ch] == 2'b11) m_rptr[ch] = ~m_rptr[ch];
                if (last) m_held[ch] = 0;
            end
            m_count[ch] = c;
        end
    endfunction

    task automatic step(bit w, bit r, logic [1:0] a, logic [7:0] d, string req);
        logic [7:0] e;
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d; cnt_ce = g_ce; cnt_gate = g_gt;
        #1;
        if (r) begin
            e = exp_byte(a);
            checks++;
            if (rdata !== e) begin
                fails++;
                $display("FAIL %s: read addr %0d got %02h expected %02h", req, a, rdata, e);
            end
        end
        @(posedge clk);
        model_edge(w, r, a, d, g_ce, g_gt);
    endtask

    task automatic ctl(logic [7:0] d, string req);   step(1, 0, 2'd3, d, req); endtask
    task automatic wr(int ch, logic [7:0] d, string req); step(1, 0, 2'(ch), d, req); endtask
    task automatic rd(int ch, string req);            step(0, 1, 2'(ch), 8'h00, req); endtask
    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 2'd0, 8'h00, "idle");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0C54));
        for (int ch = 0; ch < 3; ch++) begin
            m_count[ch] = '0; m_snap[ch] = '0; m_hold[ch] = '0; m_fmt[ch] = 2'b11;
            m_wptr[ch] = 0; m_rptr[ch] = 0; m_held[ch] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // Reset state
        rd(1, "R2 reset"); rd(1, "R2 reset");
        rd(3, "R1 control read");

        // Two-byte write staged, live read
        g_gt = 3'b000; g_ce = 3'b111;
        ctl(8'h30, "R2");
        wr(0, 8'h34, "R4");
        rd(0, "R4 staged"); rd(0, "R4 staged");
        wr(0, 8'h12, "R4");
        rd(0, "R4 loaded"); rd(0, "R12 live");

        // Single-byte formats
        ctl(8'h50, "R2"); wr(1, 8'hAB, "R3"); rd(1, "R3 low only");
        ctl(8'h60, "R2"); wr(1, 8'hCD, "R3"); rd(1, "R3 high only");
        ctl(8'h50, "R2"); rd(1, "R3 low of high load");

        // Latch while counting
        g_gt = 3'b111;
        ctl(8'h00, "R5"); idle(4);
        rd(0, "R5 snap low"); idle(2); rd(0, "R5 snap high");
        rd(0, "R7 released live"); rd(0, "R7 released live");
        ctl(8'h0F, "R5"); idle(3); ctl(8'h00, "R6"); idle(3);
        rd(0, "R6 first snapshot"); rd(0, "R6 first snapshot");
        rd(0, "R7 live");

        // Interleave across counters and within one counter
        ctl(8'hB0, "R2");
        rd(0, "R8 first byte"); wr(2, 8'h01, "R8"); rd(2, "R8 ch2 low");
        rd(0, "R8 second byte"); wr(2, 8'h00, "R9"); rd(2, "R9 ch2 high");
        g_gt = 3'b011;
        rd(2, "R9 loaded low"); rd(2, "R9 loaded high");

        // Wrap through zero
        g_gt = 3'b111;
        idle(3);
        rd(2, "R11 wrap low"); rd(2, "R11 wrap high");

        // Read-back code inert
        ctl(8'hF5, "R10"); ctl(8'hC0, "R10");
        rd(0, "R10 after read-back"); rd(0, "R10 after read-back");
        rd(3, "R1 control read");

        // Random mix
        for (int i = 0; i < 5000; i++) begin
            int k;
            logic [1:0] s;
            g_ce = 3'($urandom); g_gt = 3'($urandom);
            k = int'($urandom % 7);
            s = 2'($urandom % 3);
            case (k)
                0: idle(1);
                1, 2: rd(int'($urandom % 4), "R12 random read");
                3: wr(int'(s), 8'($urandom), "R3 random write");
                4: ctl({s, 2'(1 + $urandom % 3), 4'h0}, "R2 random program");
                5: ctl({s, 2'b00, 4'($urandom)}, "R5 random latch");
                default: ctl({2'b11, 6'($urandom)}, "R10 random read-back");
            endcase
        end

        idle(2);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule